// File: doc/BRIEF.md
# T1 Loopback Path Selector

This block steers the serial bit streams of a T1 framer datapath among four paths: normal operation and three loopbacks. In the payload loopback the received payload returns to the line, and locally generated overhead replaces the received overhead. In the framer loopback the system transmit stream is turned back into the receive framer while the line carries unframed all-ones. In the local loopback transmission continues unchanged and the receive framer sees the transmitted stream instead of the line.

The block uses a single clock. Each stream is qualified by a bit strobe, so changing the clock source of a path means picking the strobe that paces it. The block also generates the transmit channel clock and channel block pulses from the transmit frame position. A change of loopback selection takes effect only at a receive frame boundary, which is the strobed framing-bit slot. A new mode applies from that framing bit onward, so no frame is built from two modes. Payload loopback does not depend on whether the frame carries superframe or extended-superframe overhead, because the overhead bit is supplied from outside.

Top module: `t1_loopback_sel`

## Requirements
- R1: While reset is asserted every output is 0, and after reset the active mode is normal (no loopback).
- R2: In normal mode, one clock after an input cycle, line_tx_en equals that cycle's tx_bit_en and line_tx_data equals sys_tx_data. rxf_bit_en equals rx_bit_en and rxf_data equals line_rx_data.
- R3: In local loopback, the line transmit outputs behave as in R2. The receive framer is paced by tx_bit_en and gets sys_tx_data, and line_rx_data has no effect.
- R4: In payload loopback, line_tx_en follows rx_bit_en one clock later. On strobed non-framing bits line_tx_data equals rx_data, and sys_tx_data has no effect.
- R5: In payload loopback, on a strobed bit with rx_fbit_pos = 1, line_tx_data equals ovh_bit instead of rx_data.
- R6: In payload loopback, tx_chan_clk and tx_chan_blk stay 0, and the receive framer outputs behave as in R2.
- R7: In framer loopback, line_tx_en follows tx_bit_en and line_tx_data is 1 on every strobed bit. The receive framer is paced by tx_bit_en and gets sys_tx_data, and line_rx_data has no effect.
- R8: When several loopback controls are 1, framer outranks payload and payload outranks local.
- R9: The active mode changes only on a cycle with rx_bit_en = 1 and rx_fbit_pos = 1. That framing bit, and every bit after it, uses the newly requested mode.
- R10: Outside payload loopback, the transmit bit index is 0 on a strobed tx_fbit_pos and otherwise counts up by one per tx_bit_en. One clock after a strobed bit, tx_chan_blk is 1 for index 0 and tx_chan_clk is 1 for indices 1 + k*CHAN_BITS. Both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_payload | input | 1 | Request payload loopback |
| lb_framer | input | 1 | Request framer loopback |
| lb_local | input | 1 | Request local loopback |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_fbit_pos | input | 1 | Current transmit bit is the framing bit |
| sys_tx_data | input | 1 | System transmit serial data |
| rx_bit_en | input | 1 | Receive (recovered) bit strobe |
| rx_fbit_pos | input | 1 | Current receive bit is the framing/overhead bit |
| rx_data | input | 1 | Recovered receive data, bipolar violations corrected |
| ovh_bit | input | 1 | Locally generated overhead bit for the receive-timed frame |
| line_rx_data | input | 1 | Raw line receive data |
| line_tx_en | output | 1 | Line transmit bit strobe |
| line_tx_data | output | 1 | Line transmit data |
| rxf_bit_en | output | 1 | Bit strobe to the receive framer |
| rxf_data | output | 1 | Data to the receive framer |
| tx_chan_clk | output | 1 | Pulse on the first bit of each transmit channel |
| tx_chan_blk | output | 1 | Pulse on the transmit framing bit slot |

## Verification
The bench holds each of the eight control combinations across several receive frames. It changes the controls in the middle of a frame, so a design that switched modes at once would show the new routing before the framing-bit strobe. The transmit and receive strobes use different rates and phases, so taking the line timing from the wrong strobe in payload or framer loopback produces wrong enables within a few cycles. The overhead slot in payload loopback is checked against ovh_bit, which catches a design that loops the received framing bit. The data inputs that each mode must ignore carry independent pseudo-random streams, so a design that leaks one into an output shows wrong data.

// File: rtl/t1lb_pkg.sv
package t1lb_pkg;
    typedef enum logic [1:0] {
        LB_NONE    = 2'd0,
        LB_LOCAL   = 2'd1,
        LB_PAYLOAD = 2'd2,
        LB_FRAMER  = 2'd3
    } lb_mode_e;

    typedef struct packed {
        logic line_tx_en;
        logic line_tx_data;
        logic rxf_en;
        logic rxf_data;
        logic chan_clk;
        logic chan_blk;
    } path_out_s;
endpackage

// File: rtl/lb_mode_ctrl.sv
module lb_mode_ctrl
    import t1lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_payload,
    input  logic     req_framer,
    input  logic     req_local,
    input  logic     bound,
    output lb_mode_e mode_eff
);
    lb_mode_e mode_q, mode_d, req_mode;

    always_comb begin
        if (req_framer)       req_mode = LB_FRAMER;
        else if (req_payload) req_mode = LB_PAYLOAD;
        else if (req_local)   req_mode = LB_LOCAL;
        else                  req_mode = LB_NONE;
        mode_d   = bound ? req_mode : mode_q;
        mode_eff = mode_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= LB_NONE;
        else        mode_q <= mode_d;
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bound |=> mode_q == $past(mode_q));
    // R8
    framer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bound && req_framer) |=> mode_q == LB_FRAMER);
endmodule

// File: rtl/lb_chan_timer.sv
module lb_chan_timer #(
    parameter int FRAME_BITS = 193,
    parameter int CHAN_BITS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic fbit,
    output logic chan_start,
    output logic fbit_slot
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

    logic [IW-1:0] idx_q, idx_d, idx_cur;

    always_comb begin
        if (fbit)               idx_cur = '0;
        else if (idx_q == LAST) idx_cur = LAST;
        else                    idx_cur = idx_q + IW'(1);
        idx_d      = bit_en ? idx_cur : idx_q;
        fbit_slot  = bit_en && fbit;
        chan_start = bit_en && (idx_cur != '0) &&
                     (((idx_cur - IW'(1)) % IW'(CHAN_BITS)) == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // R10
    chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_start, fbit_slot}));
endmodule

// File: rtl/lb_path_mux.sv
module lb_path_mux
    import t1lb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lb_mode_e  mode,
    input  logic      tx_bit_en,
    input  logic      sys_tx_data,
    input  logic      rx_bit_en,
    input  logic      rx_fbit_pos,
    input  logic      rx_data,
    input  logic      ovh_bit,
    input  logic      line_rx_data,
    input  logic      chan_start,
    input  logic      fbit_slot,
    output path_out_s out
);
    path_out_s out_q, out_d;
    logic      tx_en_sel, tx_dat_sel, rx_en_sel, rx_dat_sel;

    always_comb begin
        unique case (mode)
            LB_PAYLOAD: begin
                tx_en_sel  = rx_bit_en;
                tx_dat_sel = rx_fbit_pos ? ovh_bit : rx_data;
            end
            LB_FRAMER: begin
                tx_en_sel  = tx_bit_en;
                tx_dat_sel = 1'b1;
            end
            default: begin
                tx_en_sel  = tx_bit_en;
                tx_dat_sel = sys_tx_data;
            end
        endcase
        if (mode == LB_LOCAL || mode == LB_FRAMER) begin
            rx_en_sel  = tx_bit_en;
            rx_dat_sel = sys_tx_data;
        end else begin
            rx_en_sel  = rx_bit_en;
            rx_dat_sel = line_rx_data;
        end

        out_d              = out_q;
        out_d.line_tx_en   = tx_en_sel;
        out_d.rxf_en       = rx_en_sel;
        if (tx_en_sel) out_d.line_tx_data = tx_dat_sel;
        if (rx_en_sel) out_d.rxf_data     = rx_dat_sel;
        out_d.chan_clk     = (mode != LB_PAYLOAD) && chan_start;
        out_d.chan_blk     = (mode != LB_PAYLOAD) && fbit_slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out = out_q;

    // R6
    payload_chan_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_PAYLOAD) |=> (!out_q.chan_clk && !out_q.chan_blk));
    // R4
    payload_rx_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_PAYLOAD) |=> out_q.line_tx_en == $past(rx_bit_en));
    // R7
    framer_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_FRAMER && tx_bit_en) |=> out_q.line_tx_data);
    // R3
    local_rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_LOCAL && tx_bit_en) |=> out_q.rxf_data == $past(sys_tx_data));
endmodule

// File: rtl/t1_loopback_sel.sv
module t1_loopback_sel
    import t1lb_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int CHAN_BITS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lb_payload,
    input  logic lb_framer,
    input  logic lb_local,
    input  logic tx_bit_en,
    input  logic tx_fbit_pos,
    input  logic sys_tx_data,
    input  logic rx_bit_en,
    input  logic rx_fbit_pos,
    input  logic rx_data,
    input  logic ovh_bit,
    input  logic line_rx_data,
    output logic line_tx_en,
    output logic line_tx_data,
    output logic rxf_bit_en,
    output logic rxf_data,
    output logic tx_chan_clk,
    output logic tx_chan_blk
);
    lb_mode_e  mode_eff;
    logic      chan_start, fbit_slot;
    path_out_s po;

    lb_mode_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_payload(lb_payload),
        .req_framer (lb_framer),
        .req_local  (lb_local),
        .bound      (rx_bit_en && rx_fbit_pos),
        .mode_eff   (mode_eff)
    );

    lb_chan_timer #(.FRAME_BITS(FRAME_BITS), .CHAN_BITS(CHAN_BITS)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (tx_bit_en),
        .fbit      (tx_fbit_pos),
        .chan_start(chan_start),
        .fbit_slot (fbit_slot)
    );

    lb_path_mux i_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_eff),
        .tx_bit_en   (tx_bit_en),
        .sys_tx_data (sys_tx_data),
        .rx_bit_en   (rx_bit_en),
        .rx_fbit_pos (rx_fbit_pos),
        .rx_data     (rx_data),
        .ovh_bit     (ovh_bit),
        .line_rx_data(line_rx_data),
        .chan_start  (chan_start),
        .fbit_slot   (fbit_slot),
        .out         (po)
    );

    assign line_tx_en   = po.line_tx_en;
    assign line_tx_data = po.line_tx_data;
    assign rxf_bit_en   = po.rxf_en;
    assign rxf_data     = po.rxf_data;
    assign tx_chan_clk  = po.chan_clk;
    assign tx_chan_blk  = po.chan_blk;
endmodule

// File: tb/test_t1_loopback_sel.sv
module test_t1_loopback_sel;
    import t1lb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FB = 17;
    localparam int CB = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic lb_payload, lb_framer, lb_local;
    logic tx_bit_en, tx_fbit_pos, sys_tx_data;
    logic rx_bit_en, rx_fbit_pos, rx_data, ovh_bit, line_rx_data;
    logic line_tx_en, line_tx_data, rxf_bit_en, rxf_data, tx_chan_clk, tx_chan_blk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_loopback_sel #(.FRAME_BITS(FB), .CHAN_BITS(CB)) i_t1_loopback_sel (
        .clk(clk), .rst_n(rst_n),
        .lb_payload(lb_payload), .lb_framer(lb_framer), .lb_local(lb_local),
        .tx_bit_en(tx_bit_en), .tx_fbit_pos(tx_fbit_pos), .sys_tx_data(sys_tx_data),
        .rx_bit_en(rx_bit_en), .rx_fbit_pos(rx_fbit_pos), .rx_data(rx_data),
        .ovh_bit(ovh_bit), .line_rx_data(line_rx_data),
        .line_tx_en(line_tx_en), .line_tx_data(line_tx_data),
        .rxf_bit_en(rxf_bit_en), .rxf_data(rxf_data),
        .tx_chan_clk(tx_chan_clk), .tx_chan_blk(tx_chan_blk)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        lb_mode_e mode_m, req, eff, prev;
        int tx_idx = 0, rx_idx = 0, cyc = 0, cidx;
        logic e_ltx_en, e_ltx_d, e_rx_en, e_rx_d, e_clk, e_blk, bnd;
        string t_tx, t_rx, t_ch;

        rst_n = 1'b0;
        {lb_payload, lb_framer, lb_local} = '0;
        {tx_bit_en, tx_fbit_pos, sys_tx_data} = '0;
        {rx_bit_en, rx_fbit_pos, rx_data, ovh_bit, line_rx_data} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "line_tx_en", line_tx_en, 1'b0);
        check("R1", "line_tx_data", line_tx_data, 1'b0);
        check("R1", "rxf_bit_en", rxf_bit_en, 1'b0);
        check("R1", "rxf_data", rxf_data, 1'b0);
        check("R1", "tx_chan_clk", tx_chan_clk, 1'b0);
        check("R1", "tx_chan_blk", tx_chan_blk, 1'b0);
        rst_n  = 1'b1;
        mode_m = LB_NONE;

        for (int seg = 0; seg < 10; seg++) begin
            int ctl = (seg < 8) ? seg : (seg == 8 ? 5 : 0);
            lb_local   = ctl[0];
            lb_payload = ctl[1];
            lb_framer  = ctl[2];
            for (int k = 0; k < 160; k++) begin
                tx_bit_en   = (cyc % 2) == 0;
                rx_bit_en   = (cyc % 3) == 1;
                tx_fbit_pos = tx_bit_en && (tx_idx == 0);
                rx_fbit_pos = rx_bit_en && (rx_idx == 0);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sys_tx_data  = lfsr[0];
                rx_data      = lfsr[3];
                ovh_bit      = lfsr[7];
                line_rx_data = lfsr[11];

                if (lb_framer)       req = LB_FRAMER;
                else if (lb_payload) req = LB_PAYLOAD;
                else if (lb_local)   req = LB_LOCAL;
                else                 req = LB_NONE;
                bnd  = rx_fbit_pos;
                prev = mode_m;
                eff  = bnd ? req : mode_m;

                e_ltx_en = (eff == LB_PAYLOAD) ? rx_bit_en : tx_bit_en;
                case (eff)
                    LB_PAYLOAD: e_ltx_d = rx_fbit_pos ? ovh_bit : rx_data;
                    LB_FRAMER:  e_ltx_d = 1'b1;
                    default:    e_ltx_d = sys_tx_data;
                endcase
                if (eff == LB_LOCAL || eff == LB_FRAMER) begin
                    e_rx_en = tx_bit_en;
                    e_rx_d  = sys_tx_data;
                end else begin
                    e_rx_en = rx_bit_en;
                    e_rx_d  = line_rx_data;
                end
                cidx  = tx_idx;
                e_blk = (eff != LB_PAYLOAD) && tx_bit_en && (cidx == 0);
                e_clk = (eff != LB_PAYLOAD) && tx_bit_en && (cidx != 0) && (((cidx - 1) % CB) == 0);

                case (eff)
                    LB_LOCAL:   begin t_tx = "R3"; t_rx = "R3"; t_ch = "R10"; end
                    LB_PAYLOAD: begin t_tx = rx_fbit_pos ? "R5" : "R4"; t_rx = "R6"; t_ch = "R6"; end
                    LB_FRAMER:  begin t_tx = "R7"; t_rx = "R7"; t_ch = "R10"; end
                    default:    begin t_tx = "R2"; t_rx = "R2"; t_ch = "R10"; end
                endcase
                if ((lb_framer + lb_payload + lb_local) > 1) begin
                    t_tx = "R8"; t_rx = "R8";
                end
                if (req != prev && !bnd) begin
                    t_tx = "R9"; t_rx = "R9";
                end

                mode_m = eff;
                if (tx_bit_en) tx_idx = (tx_idx + 1) % FB;
                if (rx_bit_en) rx_idx = (rx_idx + 1) % FB;
                cyc++;

                @(posedge clk);
                @(negedge clk);
                check(t_tx, "line_tx_en", line_tx_en, e_ltx_en);
                if (e_ltx_en) check(t_tx, "line_tx_data", line_tx_data, e_ltx_d);
                check(t_rx, "rxf_bit_en", rxf_bit_en, e_rx_en);
                if (e_rx_en) check(t_rx, "rxf_data", rxf_data, e_rx_d);
                check(t_ch, "tx_chan_clk", tx_chan_clk, e_clk);
                check(t_ch, "tx_chan_blk", tx_chan_blk, e_blk);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule